// File: doc/BRIEF.md
# Interlaced Field Detector

This block tells which field of an interlaced video signal is arriving. It takes a digital composite sync stream, already sliced, and counts the clock cycles of each gap between sync pulses. A one-bit parity flag follows the gaps. A gap at least as long as a programmable threshold clears the flag. A shorter gap, such as the half-line gaps between equalizing pulses, inverts the flag when the next sync pulse arrives.

A vertical pulse from a separate vertical detector samples the flag on its rising edge. The two field types end with a different number of half-line gaps before vertical sync, so the flag has opposite values at vertical start on alternate fields. The sampled value is held on the field output until the next vertical pulse: high marks the odd field and low marks the even field.

The threshold is given in clock cycles and is normally set to about three quarters of one line period. It must be longer than a half line and shorter than a full line.

Top module: `field_detector`

## Requirements
- R1: Synchronous active-low reset clears the gap timer and the parity flag, and sets the field output low (even) from the clock edge that samples reset low.
- R2: Composite sync is active high. The gap length is the number of clock cycles the sync input was low before it rises, and the timer restarts from zero whenever sync is high.
- R3: At each sync rising edge, a gap length greater than or equal to the threshold leaves the parity flag at 0. A gap length of threshold minus one or less inverts the flag.
- R4: A clear is not postponed until the next sync edge. Once the running gap reaches the threshold while sync is still low, the flag is 0.
- R5: On a vertical rising edge the field output takes the flag value: flag 1 gives output 1 (odd) and flag 0 gives output 0 (even), with the default polarity parameter ODD_ON_SET = 1. If a sync rising edge falls in the same cycle, the flag value from before that edge's update is used.
- R6: Between vertical rising edges the field output holds its value, whatever the sync input does.
- R7: The gap timer saturates at its all-ones value (4095 with the default 12-bit width). A gap longer than that still counts as a long gap and never wraps into a short one.
- R8: The field output changes on the second rising clock edge after the vertical input rises: one input register stage and one output register.
- R9: Two fields whose runs of short gaps before the vertical edge differ in length by one produce opposite field output values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| csync_i | input | 1 | Composite sync, high while sync is active |
| vsync_i | input | 1 | Vertical pulse from the vertical detector; its rising edge samples the flag |
| gap_thr_i | input | GAP_W | Long-gap threshold in clock cycles |
| field_odd_o | output | 1 | Field index: 1 for odd, 0 for even |

## Verification
Two events can land in the same clock cycle. A vertical rising edge can capture the parity flag while a sync rising edge is updating that flag. The bench raises both inputs on the same falling clock edge at the serration pulse, and it expects the field output to carry the flag value from before that pulse's update. A second pairing is a vertical edge inside a gap that has already passed the threshold. There the clear made during the gap, not the later sync edge, must decide the result. Threshold-minus-one and threshold-exact gaps, and a gap long enough to wrap an unsaturated timer, are judged the same way through the field output.

// File: rtl/field_det_pkg.sv
// Package: shared types for the interlaced field detector.
// Assumes: nothing beyond IEEE 1800-2017.
package field_det_pkg;

    // Encoding of the field output level.
    typedef enum logic {
        FIELD_EVEN = 1'b0,
        FIELD_ODD  = 1'b1
    } field_e;

    // Registered view of one sampled input: its level and its rising edge.
    typedef struct packed {
        logic level;
        logic rise;
    } edge_t;

endpackage

// File: rtl/fd_edge_track.sv
// Module: fd_edge_track
// Registers one input that is already synchronous to clk. It reports the
// registered level and a one-cycle rising-edge strobe.
// Assumes: the input is already synchronous; no metastability filtering here.
module fd_edge_track
    import field_det_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sig_i,
    output edge_t ev_o
);

    logic stage_now;
    logic stage_prev;

    // Two-deep shift register: current sample and the sample one cycle older.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_now  <= 1'b0;
            stage_prev <= 1'b0;
        end else begin
            stage_now  <= sig_i;
            stage_prev <= stage_now;
        end
    end

    // Level and rising-edge strobe taken from the two stages.
    always_comb begin
        ev_o.level = stage_now;
        ev_o.rise  = stage_now & ~stage_prev;
    end

endmodule

// File: rtl/fd_gap_timer.sv
// Module: fd_gap_timer
// Counts clock cycles while sync is inactive and restarts from zero while
// sync is active. The count saturates at all ones. Flags a long gap when
// the count is at or above the threshold.
// Assumes: sync level is registered (one cycle behind the pin).
module fd_gap_timer #(
    parameter int GAP_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_lvl_i,
    input  logic [GAP_W-1:0] thr_i,
    output logic [GAP_W-1:0] cnt_o,
    output logic             long_o
);

    localparam logic [GAP_W-1:0] CNT_MAX = {GAP_W{1'b1}};

    logic [GAP_W-1:0] cnt_q;

    // Gap counter: cleared by active sync, otherwise counts up to saturation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (sync_lvl_i) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Long-gap comparison against the programmable threshold.
    always_comb begin
        cnt_o  = cnt_q;
        long_o = (cnt_q >= thr_i);
    end

endmodule

// File: rtl/fd_parity_flag.sv
// Module: fd_parity_flag
// Parity flag over sync gaps. A sync rising edge inverts the flag after a
// short gap and clears it after a long one. A gap that reaches the
// threshold while sync is still low clears the flag at once.
// Assumes: gap_long_i reflects the gap that ends at the rising edge.
module fd_parity_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_rise_i,
    input  logic sync_lvl_i,
    input  logic gap_long_i,
    output logic flag_o
);

    logic flag_q;

    // Flag update: edge decision first, in-gap clear otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (sync_rise_i) begin
            flag_q <= gap_long_i ? 1'b0 : ~flag_q;
        end else if (gap_long_i && !sync_lvl_i) begin
            flag_q <= 1'b0;
        end
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/fd_field_latch.sv
// Module: fd_field_latch
// Samples the parity flag on a vertical rising edge and holds it as the
// field index. ODD_ON_SET chooses which flag value means odd.
// Assumes: flag_i is the registered flag, so a coincident sync edge is
// seen as its pre-update value.
module fd_field_latch
    import field_det_pkg::*;
#(
    parameter bit ODD_ON_SET = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic v_rise_i,
    input  logic flag_i,
    output logic field_o
);

    logic   odd_now;
    field_e field_q;

    // Polarity variant chosen at elaboration.
    generate
        if (ODD_ON_SET) begin : g_direct
            assign odd_now = flag_i;
        end else begin : g_inverted
            assign odd_now = ~flag_i;
        end
    endgenerate

    // Field register: loads on vertical rising edge only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            field_q <= FIELD_EVEN;
        end else if (v_rise_i) begin
            field_q <= odd_now ? FIELD_ODD : FIELD_EVEN;
        end
    end

    assign field_o = (field_q == FIELD_ODD);

endmodule

// File: rtl/field_detector.sv
// Module: field_detector (top)
// Identifies odd/even fields of an interlaced signal from a sliced
// composite sync and a vertical pulse.
// Assumes: csync_i and vsync_i are synchronous to clk; gap_thr_i lies
// between a half line and a full line, in clock cycles.
module field_detector
    import field_det_pkg::*;
#(
    parameter int GAP_W      = 12,
    parameter bit ODD_ON_SET = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             csync_i,
    input  logic             vsync_i,
    input  logic [GAP_W-1:0] gap_thr_i,
    output logic             field_odd_o
);

    edge_t            sync_ev;
    edge_t            vert_ev;
    logic             sync_lvl;
    logic             sync_rise;
    logic             v_lvl;
    logic             v_rise;
    logic [GAP_W-1:0] gap_cnt;
    logic             gap_long;
    logic             flag;

    // Input registers for composite sync and vertical pulse.
    fd_edge_track u_sync_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sig_i (csync_i),
        .ev_o  (sync_ev)
    );

    fd_edge_track u_vert_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sig_i (vsync_i),
        .ev_o  (vert_ev)
    );

    // Unpack edge views for readability.
    always_comb begin
        sync_lvl  = sync_ev.level;
        sync_rise = sync_ev.rise;
        v_lvl     = vert_ev.level;
        v_rise    = vert_ev.rise;
    end

    fd_gap_timer #(
        .GAP_W (GAP_W)
    ) u_gap_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_lvl_i (sync_lvl),
        .thr_i      (gap_thr_i),
        .cnt_o      (gap_cnt),
        .long_o     (gap_long)
    );

    fd_parity_flag u_parity (
        .clk         (clk),
        .rst_n       (rst_n),
        .sync_rise_i (sync_rise),
        .sync_lvl_i  (sync_lvl),
        .gap_long_i  (gap_long),
        .flag_o      (flag)
    );

    fd_field_latch #(
        .ODD_ON_SET (ODD_ON_SET)
    ) u_field (
        .clk      (clk),
        .rst_n    (rst_n),
        .v_rise_i (v_rise),
        .flag_i   (flag),
        .field_o  (field_odd_o)
    );

endmodule

// File: rtl/field_detector_chk.sv
// Module: field_detector_chk
// Property checker bound into field_detector. It watches the timer, the
// flag and the field register across module boundaries.
// Assumes: bound with the internal signal names of field_detector.
module field_detector_chk #(
    parameter int GAP_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sync_lvl,
    input logic             sync_rise,
    input logic             v_lvl,
    input logic             v_rise,
    input logic [GAP_W-1:0] gap_cnt,
    input logic             gap_long,
    input logic             flag,
    input logic             field_odd_o
);

    localparam logic [GAP_W-1:0] CNT_MAX = {GAP_W{1'b1}};

    // Reset state of timer, flag and field.
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (!field_odd_o && !flag && gap_cnt == '0));

    // Active sync restarts the timer.
    assert_timer_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sync_lvl |=> (gap_cnt == '0));

    // The flag changes only at a sync edge or through a long-gap clear.
    assert_flag_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (flag != $past(flag)) |-> ($past(sync_rise) || $past(gap_long && !sync_lvl)));

    // A long gap seen while sync is low leaves the flag at zero.
    assert_gap_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_long && !sync_lvl) |=> !flag);

    // The field output moves only after a vertical rising edge.
    assert_field_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (field_odd_o != $past(field_odd_o)) |-> ($past(v_rise) && $past(v_lvl)));

    // The timer stays saturated through an ongoing gap.
    assert_timer_sat_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_cnt == CNT_MAX && !sync_lvl) |=> (gap_cnt == CNT_MAX));

endmodule

bind field_detector field_detector_chk #(
    .GAP_W (GAP_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sync_lvl    (sync_lvl),
    .sync_rise   (sync_rise),
    .v_lvl       (v_lvl),
    .v_rise      (v_rise),
    .gap_cnt     (gap_cnt),
    .gap_long    (gap_long),
    .flag        (flag),
    .field_odd_o (field_odd_o)
);

// File: tb/field_detector_tb.sv
// Scoreboard bench for field_detector. The driver computes the expected
// field from the gaps it drives. The monitor compares after each vertical
// rising edge.
module field_detector_tb;

    localparam int GAP_W = 12;
    localparam int THR   = 75;
    localparam int FULL  = 96;
    localparam int HALF  = 46;
    localparam int SW    = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             csync_i = 1'b0;
    logic             vsync_i = 1'b0;
    logic [GAP_W-1:0] gap_thr_i = GAP_W'(THR);
    logic             field_odd_o;

    int    checks = 0;
    int    fails = 0;
    bit    flag_m = 1'b0;
    bit    last_exp = 1'b0;
    bit    exp_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;

    field_detector #(
        .GAP_W      (GAP_W),
        .ODD_ON_SET (1'b1)
    ) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .csync_i     (csync_i),
        .vsync_i     (vsync_i),
        .gap_thr_i   (gap_thr_i),
        .field_odd_o (field_odd_o)
    );

    task automatic check(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: field_odd_o actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Driver: sync low for gap cycles, then high for width cycles. The
    // vertical pulse may rise on the same edge as the sync.
    task automatic sync_pulse(int gap, int width, bit with_v, string tag);
        csync_i = 1'b0;
        repeat (gap) @(negedge clk);
        if (with_v) begin
            exp_q.push_back(flag_m);      // R5: pre-update flag
            tag_q.push_back(tag);
        end
        csync_i = 1'b1;
        if (with_v) vsync_i = 1'b1;
        flag_m = (gap < THR) ? ~flag_m : 1'b0;   // R3 model
        repeat (width) @(negedge clk);
        vsync_i = 1'b0;
    endtask

    // Driver: vertical pulse rises inside a gap already past threshold.
    task automatic vert_in_gap(int gap, int vpos, string tag);
        csync_i = 1'b0;
        repeat (vpos) @(negedge clk);
        exp_q.push_back(1'b0);            // R4: cleared during gap
        tag_q.push_back(tag);
        vsync_i = 1'b1;
        repeat (gap - vpos) @(negedge clk);
        vsync_i = 1'b0;
        csync_i = 1'b1;
        flag_m = 1'b0;
        repeat (SW) @(negedge clk);
    endtask

    task automatic lines(int n);
        for (int i = 0; i < n; i++) sync_pulse(FULL, SW, 1'b0, "");
    endtask

    // Monitor: latency checks and scoreboard compare on each vertical.
    initial begin
        forever begin
            @(posedge vsync_i);
            @(negedge clk);
            check("R8 before update", field_odd_o, last_exp);
            @(negedge clk);
            if (exp_q.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL R5: unexpected vertical, actual=%0b expected=none", field_odd_o);
            end else begin
                last_exp = exp_q.pop_front();
                check(tag_q.pop_front(), field_odd_o, last_exp);
                @(negedge clk);
                check("R8 settled", field_odd_o, last_exp);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        check("R1 reset", field_odd_o, 1'b0);
        rst_n = 1'b1;

        lines(5);

        // Even pattern: six short gaps, vertical on the seventh pulse.
        for (int i = 0; i < 6; i++) sync_pulse(HALF, SW, 1'b0, "");
        sync_pulse(HALF, SW, 1'b1, "R9 even field");
        for (int i = 0; i < 5; i++) sync_pulse(HALF, SW, 1'b0, "");
        lines(6);

        // Odd pattern: one extra half line before the equalizing run.
        for (int i = 0; i < 7; i++) sync_pulse(HALF, SW, 1'b0, "");
        sync_pulse(HALF, SW, 1'b1, "R9 odd field");
        for (int i = 0; i < 5; i++) sync_pulse(HALF, SW, 1'b0, "");

        // Hold: lines and short gaps without a vertical edge.
        lines(3);
        sync_pulse(HALF, SW, 1'b0, "");
        check("R6 hold", field_odd_o, last_exp);
        lines(2);
        check("R6 hold after lines", field_odd_o, last_exp);

        // Clear inside a long gap, with the flag set beforehand.
        sync_pulse(HALF, SW, 1'b0, "");
        vert_in_gap(FULL + 10, THR + 10, "R4 in-gap clear");

        // Threshold boundaries.
        lines(2);
        sync_pulse(THR - 1, SW, 1'b0, "");
        sync_pulse(HALF, SW, 1'b1, "R3 gap thr-1 toggles");
        sync_pulse(HALF, SW, 1'b0, "");
        sync_pulse(THR, SW, 1'b0, "");
        sync_pulse(HALF, SW, 1'b1, "R3 gap equal thr clears");
        lines(2);

        // Saturation of the gap timer.
        sync_pulse(HALF, SW, 1'b0, "");
        sync_pulse(4100, SW, 1'b0, "");
        sync_pulse(HALF, SW, 1'b1, "R7 saturated gap is long");
        lines(2);

        // Odd again, then reset in mid run.
        sync_pulse(HALF, SW, 1'b0, "");
        sync_pulse(HALF, SW, 1'b1, "R5 odd capture");
        sync_pulse(HALF, SW, 1'b0, "");
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        csync_i = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset mid run", field_odd_o, 1'b0);
        rst_n = 1'b1;
        flag_m = 1'b0;
        last_exp = 1'b0;
        sync_pulse(HALF, SW, 1'b1, "R1 flag cleared by reset");
        lines(2);

        repeat (10) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++;
            fails++;
            $display("FAIL R5: pending=%0d expected=0", exp_q.size());
        end
        finish_run();
    end

endmodule